// File: doc/BRIEF.md
# Watchdog Timer with Sequenced Refresh

This block is a down-counting watchdog behind a byte-wide register port. Software starts the count by writing any value to a start register. After that the count cannot be stopped except by a system reset. To keep the count from running out, software writes 00h and then FFh to a refresh register, and that pair reloads the preset. When the count reaches zero with counting enabled, the block pulses an underflow event for one clock and reloads itself. A reset or interrupt controller outside the block consumes that event.

A protection control bit sits in a third register. Software can set it only with a two-write handshake, and once set it cannot be cleared by software. It switches the preset from 7FFFh to the shorter 0FFFh. It also reloads the counter with 0FFFh at the moment it becomes set. A power-on configuration input can make the bit start out set from reset. An external count enable, driven by the count-source logic, decides which clock cycles count.

Top module: `wdog_seq`

## Requirements
- R1: After a reset with `por_prot` low, a read of any address returns 00h, `underflow` is low, and the counter holds 7FFFh in the stopped state.
- R2: Before the start register (address 0Eh) is written, the count does not decrease, whatever `cnt_en` does.
- R3: A write of any data to address 0Eh starts the count. After that, each cycle with `cnt_en` high lowers the count by one. The first underflow appears preset+1 enabled cycles after the start write.
- R4: `underflow` is high for exactly one cycle, the cycle in which the count is zero and `cnt_en` is high. The counter then reloads the current preset, so the next underflow follows preset+1 enabled cycles later.
- R5: A write of 00h to the refresh register (address 0Dh) followed by a write of FFh to that register reloads the preset. The underflow then comes preset+1 enabled cycles after the FFh write.
- R6: A write of FFh to 0Dh does not reload unless the most recent earlier write to 0Dh was 00h. A write to 0Dh with any other data cancels a pending 00h. Writes to other addresses leave a pending 00h intact.
- R7: The preset is 7FFFh while protection is off and 0FFFh while protection is on.
- R8: Address 1Ch reads the protection bit at bit 7. Bits 6..0 always read as 0. Addresses 0Dh and 0Eh read as 00h.
- R9: The protection bit becomes 1 only when a write to 1Ch with bit 7 = 0 is followed by a bus write that is to 1Ch with bit 7 = 1, with no other bus write between the two. A lone write of 1 has no effect.
- R10: Once the protection bit is 1, software writes cannot clear it. Only a reset does.
- R11: The write that sets the protection bit loads the counter with 0FFFh.
- R12: With `por_prot` high during reset, address 1Ch reads 80h after reset and the counter starts from 0FFFh.
- R13: Cycles with `cnt_en` low do not count, so they delay the underflow by exactly their number.
- R14: Once started, the counter stays started until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_prot | input | 1 | Power-on configuration: protection set from reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cnt_en | input | 1 | Count enable from the count-source logic |
| underflow | output | 1 | One-cycle pulse when the count runs out |

## Verification
Some properties are checked on every cycle by assertions in the logic:
- the protection bit and the started state never fall back;
- the count is frozen before the start write;
- each enabled cycle lowers the count by exactly one;
- an underflow is followed by a reload to the current preset and is never two cycles long;
- any load lands on the selected preset.

Other behaviour shows only at the ports, over the bench's scenarios:
- the exact cycle of each underflow after a start, a refresh, a pause in `cnt_en` or a change of protection;
- the ordering rules of the two write handshakes, including interleaved foreign writes and the data values that cancel them;
- the read-back values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 16;

  typedef logic [CNT_W-1:0] cnt_t;

  // preset chosen by the protection state
  function automatic cnt_t preset_sel(input logic prot_on, input cnt_t open_val,
                                      input cnt_t prot_val);
    return prot_on ? prot_val : open_val;
  endfunction

  // one step of the countdown, load taking priority over counting
  function automatic cnt_t count_step(input cnt_t cur, input logic run,
                                      input logic load, input cnt_t preset);
    if (load)            return preset;
    else if (!run)       return cur;
    else if (cur == '0)  return preset;
    else                 return cur - cnt_t'(1);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PROT_BIT  = 7,
  parameter logic [ADDR_W-1:0] A_REFRESH = 8'h0D,
  parameter logic [ADDR_W-1:0] A_START   = 8'h0E,
  parameter logic [ADDR_W-1:0] A_PROT    = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_prot,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              prot,
  output logic              refresh_ev,
  output logic              start_ev,
  output logic              prot_set_ev
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic wr_ref, wr_prot;
  logic ref_armed, prot_armed;

  assign wr_ref   = we && (addr == A_REFRESH);
  assign wr_prot  = we && (addr == A_PROT);
  assign start_ev = we && (addr == A_START);

  assign refresh_ev  = wr_ref && (wdata == ALL_ONES) && ref_armed;
  assign prot_set_ev = wr_prot && wdata[PROT_BIT] && prot_armed && !prot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_armed  <= 1'b0;
      prot_armed <= 1'b0;
      prot       <= por_prot;
    end else begin
      if (wr_ref) ref_armed <= (wdata == '0);
      if (we)     prot_armed <= wr_prot && !wdata[PROT_BIT];
      if (prot_set_ev) prot <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_PROT) rdata[PROT_BIT] = prot;
  end

  // R10: protection never falls back while out of reset
  p_prot_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> prot);

  // R9: the bit rises only on a write of 1 to the protection register
  p_prot_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot && !(wr_prot && wdata[PROT_BIT])) |=> !prot);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter cnt_t PRESET_OPEN = 16'h7FFF,
  parameter cnt_t PRESET_PROT = 16'h0FFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_prot,
  input  logic prot_next,
  input  logic load,
  input  logic start_ev,
  input  logic cnt_en,
  output logic underflow
);
  cnt_t cnt, preset;
  logic started, run;

  assign preset    = preset_sel(prot_next, PRESET_OPEN, PRESET_PROT);
  assign run       = started && cnt_en;
  assign underflow = run && (cnt == '0) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      cnt     <= preset_sel(por_prot, PRESET_OPEN, PRESET_PROT);
    end else begin
      if (start_ev) started <= 1'b1;
      cnt <= count_step(cnt, run, load, preset);
    end
  end

  // R14: once started, stays started
  p_start_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> started);

  // R2: frozen before start unless loaded
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && !load) |=> $stable(cnt));

  // R3 / R13: one decrement per enabled cycle
  p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cnt_en && !load && cnt != '0) |=> (cnt == cnt_t'($past(cnt) - 1'b1)));

  // R4: underflow reloads the preset and lasts one cycle
  p_uf_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (cnt == $past(preset)) && !underflow);

  // R5 / R11: any load lands on the selected preset
  p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == PRESET_OPEN || cnt == PRESET_PROT) && cnt == $past(preset));
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
#(
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 8,
  parameter cnt_t PRESET_OPEN = 16'h7FFF,
  parameter cnt_t PRESET_PROT = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_prot,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_en,
  output logic              underflow
);
  logic prot, refresh_ev, start_ev, prot_set_ev;
  logic load, prot_next;

  assign load      = refresh_ev || prot_set_ev;
  assign prot_next = prot || prot_set_ev;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .por_prot(por_prot),
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
    .prot(prot), .refresh_ev(refresh_ev), .start_ev(start_ev),
    .prot_set_ev(prot_set_ev)
  );

  wdog_counter #(.PRESET_OPEN(PRESET_OPEN), .PRESET_PROT(PRESET_PROT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .por_prot(por_prot), .prot_next(prot_next),
    .load(load), .start_ev(start_ev), .cnt_en(cnt_en), .underflow(underflow)
  );

  // R11: setting protection and refreshing are both loads; never two events at once
  p_single_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(refresh_ev && prot_set_ev));
endmodule

// File: tb/tb_wdog_seq.sv
module tb_wdog_seq;
  localparam int T_CLK  = 10;
  localparam int P_OPEN = 32'h7FFF;
  localparam int P_PROT = 32'h0FFF;

  logic clk = 1'b0, rst_n = 1'b0, por_prot = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_we = 1'b0, cnt_en = 1'b1;
  logic [7:0] bus_rdata;
  logic underflow;

  int cyc = 0, uf_n = 0, uf_cyc = 0, vecs = 0, bad = 0;

  wdog_seq dut (.clk(clk), .rst_n(rst_n), .por_prot(por_prot), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_en(cnt_en), .underflow(underflow));

  always #(T_CLK/2) clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (underflow) begin uf_n = uf_n + 1; uf_cyc = cyc; end
  end

  task automatic done();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 190000) begin
    vecs++; bad++;
    $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
    done();
  end

  task automatic chk(input int act, input int exp, input string req);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); #1; bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    chk(int'(bus_rdata), exp, req);
    bus_addr = '0;
  endtask

  // waits for the next underflow and checks the cycle it lands on
  task automatic expect_uf(input int exp, input string req);
    int n0 = uf_n;
    while (uf_n == n0 && cyc < exp + 50) begin @(negedge clk); #1; end
    chk(uf_n - n0, 1, {req, " underflow count"});
    chk(uf_cyc, exp, {req, " underflow cycle"});
    @(negedge clk); #1;
    chk(int'(underflow), 0, "R4 pulse width");
  endtask

  initial begin
    int l, u, n0;
    repeat (3) @(negedge clk);
    #1; rst_n = 1'b1;
    // R1 / R8: reset state and read-back
    chk(int'(underflow), 0, "R1 underflow at reset");
    rd(8'h1C, 8'h00, "R1 prot reg reset");
    rd(8'h0D, 8'h00, "R8 refresh reads zero");
    rd(8'h0E, 8'h00, "R8 start reads zero");
    // R9: lone 1, reserved bits, broken sequence
    wr(8'h1C, 8'h80); rd(8'h1C, 8'h00, "R9 lone write of 1");
    wr(8'h1C, 8'h7F); rd(8'h1C, 8'h00, "R8 reserved bits read 0");
    wr(8'h0D, 8'h55); wr(8'h1C, 8'h80); rd(8'h1C, 8'h00, "R9 interrupted sequence");
    // R2: no count before start
    n0 = uf_n; repeat (3000) @(negedge clk);
    chk(uf_n - n0, 0, "R2 stopped no underflow");
    // R3 / R7 / R1: start, full 7FFFh run from an untouched count
    wr(8'h0E, 8'h5A); l = cyc;
    expect_uf(l + P_OPEN, "R3 first underflow open preset");
    // R5: refresh in open mode
    repeat (200) @(negedge clk);
    wr(8'h0D, 8'h00); wr(8'h0D, 8'hFF); l = cyc;
    expect_uf(l + P_OPEN, "R5 refresh reload 7FFF");
    // R9 / R11: enable protection
    wr(8'h1C, 8'h00); wr(8'h1C, 8'h80); l = cyc;
    rd(8'h1C, 8'h80, "R9 prot set");
    expect_uf(l + P_PROT, "R11 load 0FFF on enable");
    // R4: natural reload at protected preset
    u = uf_cyc;
    wr(8'h1C, 8'h00); rd(8'h1C, 8'h80, "R10 write 0 ignored");
    wr(8'h1C, 8'h7F); rd(8'h1C, 8'h80, "R10 sticky");
    expect_uf(u + P_PROT + 1, "R4 natural reload");
    // R6: lone FF
    u = uf_cyc; repeat (100) @(negedge clk);
    wr(8'h0D, 8'hFF);
    expect_uf(u + P_PROT + 1, "R6 lone FF no reload");
    // R6: other data cancels pending
    u = uf_cyc;
    wr(8'h0D, 8'h00); wr(8'h0D, 8'h12); wr(8'h0D, 8'hFF);
    expect_uf(u + P_PROT + 1, "R6 cancel by other data");
    // R6 / R7: foreign write keeps pending; reload to 0FFF
    wr(8'h0D, 8'h00); wr(8'h0E, 8'h33); wr(8'h0D, 8'hFF); l = cyc;
    expect_uf(l + P_PROT, "R7 refresh reload 0FFF");
    // R13: pause
    wr(8'h0D, 8'h00); wr(8'h0D, 8'hFF); l = cyc;
    repeat (10) @(negedge clk);
    cnt_en = 1'b0; repeat (37) @(negedge clk); cnt_en = 1'b1;
    expect_uf(l + P_PROT + 37, "R13 pause delays");
    // R14: still running with no further start
    u = uf_cyc;
    expect_uf(u + P_PROT + 1, "R14 keeps running");
    // R12: power-on protection
    @(negedge clk); rst_n = 1'b0; por_prot = 1'b1;
    repeat (3) @(negedge clk);
    #1; rst_n = 1'b1;
    rd(8'h1C, 8'h80, "R12 reset value 80");
    wr(8'h0E, 8'h00); l = cyc;
    expect_uf(l + P_PROT, "R12 counter from 0FFF");
    done();
  end
endmodule